// File: doc/BRIEF.md
# Multi-Stream Stride Prefetcher

This block watches the cache-line addresses of demand accesses and learns streams that advance by a constant stride. It keeps up to eight streams in a small table. Each entry holds the newest demand line, a signed stride, a furthest-prefetched pointer, a run-ahead count and a two-bit confidence state. A stream is confirmed once three evenly spaced accesses have been seen. From then on the block sends prefetch line addresses on a valid/ready port, up to a configurable distance beyond the latest demand and never past the page of that demand. A new stream displaces the least recently touched entry.

Two simpler next-line modes bypass the table. In one, every access produces a request for the following line. In the other, only accesses flagged as misses do. A fourth mode silences the block. The mode is chosen with a two-bit input.

Each entry's confidence moves through four named states. CF_IDLE is an unused entry. CF_SEEN means one address is known. CF_TRAIN means a stride has been measured. CF_STEADY means the stream is confirmed and issuing.
- ALLOC: any state goes to CF_SEEN.
- RETRAIN: a nearby mismatch moves CF_SEEN, CF_TRAIN or CF_STEADY to CF_TRAIN.
- MATCH: CF_TRAIN goes to CF_STEADY, and CF_STEADY stays in CF_STEADY.

The request port is a two-state machine.
- OUT_IDLE goes to OUT_BUSY when a candidate is loaded.
- OUT_BUSY stays in OUT_BUSY while it holds a request or reloads on an accepted handshake.
- OUT_BUSY returns to OUT_IDLE when a request is accepted and no candidate is waiting.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, pf_valid is low and every table entry is empty, so no request appears until a stream has been learned.
- R2: In mode 2'b00, demand lines L, L+S and L+2S with 0 < |S| < 16 confirm a stream. Requests for L+3S, L+4S, and so on follow in order, one per cycle while pf_ready is high, the first in the cycle after the confirming access.
- R3: A confirmed stream runs at most 12 strides past its latest demand line. Each further matching demand frees one more request. A demand to a stream in the cycle it would issue delays that stream by one cycle; if nothing was outstanding, the stream restarts one stride beyond that demand. No line is requested twice and none is skipped ahead of the demand.
- R4: Repeated accesses to the same line (stride zero) never confirm a stream and produce no request.
- R5: Negative strides are learned and followed the same way as positive ones.
- R6: Eight streams live side by side. A new stream replaces the entry touched least recently, so a stream pushed out by eight newer ones no longer confirms.
- R7: An access within 15 lines of an entry that does not match its predicted line retrains that entry. The stride becomes the new distance and the entry drops back to needing one more matching access. Issuing then resumes with the new stride.
- R8: No request leaves the 64-line page (line address bits above bit 5) of the stream's latest demand line.
- R9: In mode 2'b01, every access to line L produces a request for L+1 in the next cycle when the port is free.
- R10: In mode 2'b10, only accesses with acc_miss high produce a request for L+1; accesses with acc_miss low produce none.
- R11: In mode 2'b11, no request is raised.
- R12: While pf_valid is high and pf_ready is low, pf_valid stays high and pf_line does not change.
- R13: The stride table learns and issues only in mode 2'b00; accesses in other modes leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 stride, 01 next line on every access, 10 next line on miss, 11 off |
| acc_valid | input | 1 | Demand access present |
| acc_line | input | ADDR_W | Demand cache-line address |
| acc_miss | input | 1 | Demand access missed the cache |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Consumer accepts the request |
| pf_line | output | ADDR_W | Requested cache-line address |

## Verification
A demand access to a confirmed stream and that stream's own issue can fall in the same cycle, since both want to rewrite the same entry's pointer and run-ahead count. The bench provokes this by sending the fourth evenly spaced access on the exact edge where the first request would load. It also sends a later matching demand while the stream sits at full run-ahead. The scoreboard expects a gap-free, duplicate-free line sequence starting one stride beyond the newest demand, and flags any line that is missing, repeated or unexpected.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;

    typedef enum logic [1:0] {
        MODE_STRIDE    = 2'b00,
        MODE_NEXT_ALL  = 2'b01,
        MODE_NEXT_MISS = 2'b10,
        MODE_OFF       = 2'b11
    } pf_mode_e;

    typedef enum logic [1:0] {
        CF_IDLE   = 2'b00,
        CF_SEEN   = 2'b01,
        CF_TRAIN  = 2'b10,
        CF_STEADY = 2'b11
    } conf_e;

    typedef enum logic [1:0] {
        UPD_NONE    = 2'b00,
        UPD_MATCH   = 2'b01,
        UPD_RETRAIN = 2'b10,
        UPD_ALLOC   = 2'b11
    } upd_e;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_BUSY = 1'b1
    } out_state_e;

endpackage

// File: rtl/pf_lru.sv
`timescale 1ns/1ps
module pf_lru #(
    parameter int NUM = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   touch_valid,
    input  logic [$clog2(NUM)-1:0] touch_idx,
    output logic [$clog2(NUM)-1:0] victim_idx
);
    localparam int IDX_W = $clog2(NUM);

    // Ages form a permutation of 0..NUM-1; the oldest entry holds NUM-1.
    logic [IDX_W-1:0] age_q [NUM];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else if (touch_valid) begin
            for (int i = 0; i < NUM; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < NUM; i++) begin
            if (age_q[i] == IDX_W'(NUM - 1)) begin
                victim_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pf_stream_table.sv
`timescale 1ns/1ps
module pf_stream_table
    import pf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM       = 8,
    parameter int DIST      = 12,
    parameter int WINDOW    = 16,
    parameter int PAGE_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_line,
    input  logic              issue_en,
    input  logic              take,
    output logic              cand_valid,
    output logic [ADDR_W-1:0] cand_line
);
    localparam int IDX_W = $clog2(NUM);
    localparam int CNT_W = $clog2(DIST + 1);
    localparam logic [ADDR_W-1:0] WIN_POS = ADDR_W'(WINDOW);
    localparam logic [ADDR_W-1:0] WIN_NEG = ADDR_W'(-WINDOW);

    conf_e             conf_q   [NUM];
    logic [ADDR_W-1:0] last_q   [NUM];
    logic [ADDR_W-1:0] stride_q [NUM];
    logic [ADDR_W-1:0] ptr_q    [NUM];
    logic [CNT_W-1:0]  ahead_q  [NUM];

    logic [ADDR_W-1:0] next_arr [NUM];
    logic [NUM-1:0]    match_v;
    logic [NUM-1:0]    near_v;
    logic [NUM-1:0]    elig_v;

    upd_e              touch_kind;
    logic              touch_valid;
    logic [IDX_W-1:0]  touch_idx;
    logic [IDX_W-1:0]  victim_idx;
    logic [IDX_W-1:0]  cand_idx;

    pf_lru #(.NUM(NUM)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .victim_idx  (victim_idx)
    );

    // Per-entry compare and issue eligibility.
    for (genvar g = 0; g < NUM; g++) begin : g_ent
        logic [ADDR_W-1:0] diff;
        logic              trained;
        logic              same_page;
        assign diff        = acc_line - last_q[g];
        assign trained     = (conf_q[g] == CF_TRAIN) || (conf_q[g] == CF_STEADY);
        assign match_v[g]  = trained && (stride_q[g] != '0)
                             && (acc_line == last_q[g] + stride_q[g]);
        assign near_v[g]   = (conf_q[g] != CF_IDLE)
                             && ($signed(diff) < $signed(WIN_POS))
                             && ($signed(diff) > $signed(WIN_NEG));
        assign next_arr[g] = ptr_q[g] + stride_q[g];
        assign same_page   = next_arr[g][ADDR_W-1:PAGE_LOG2] == last_q[g][ADDR_W-1:PAGE_LOG2];
        assign elig_v[g]   = issue_en && (conf_q[g] == CF_STEADY)
                             && (ahead_q[g] < CNT_W'(DIST)) && same_page
                             && !(touch_valid && (touch_idx == IDX_W'(g)));
    end

    // Access classification: match first, then nearby retrain, else allocate.
    always_comb begin
        logic             m_hit;
        logic             n_hit;
        logic [IDX_W-1:0] m_idx;
        logic [IDX_W-1:0] n_idx;
        m_hit = 1'b0;
        n_hit = 1'b0;
        m_idx = '0;
        n_idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (match_v[i]) begin
                m_hit = 1'b1;
                m_idx = IDX_W'(i);
            end
            if (near_v[i]) begin
                n_hit = 1'b1;
                n_idx = IDX_W'(i);
            end
        end
        touch_kind = UPD_NONE;
        touch_idx  = victim_idx;
        if (acc_valid) begin
            if (m_hit) begin
                touch_kind = UPD_MATCH;
                touch_idx  = m_idx;
            end else if (n_hit) begin
                touch_kind = UPD_RETRAIN;
                touch_idx  = n_idx;
            end else begin
                touch_kind = UPD_ALLOC;
                touch_idx  = victim_idx;
            end
        end
    end

    assign touch_valid = (touch_kind != UPD_NONE);

    // Lowest-index eligible stream issues.
    always_comb begin
        cand_valid = 1'b0;
        cand_idx   = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (elig_v[i]) begin
                cand_valid = 1'b1;
                cand_idx   = IDX_W'(i);
            end
        end
    end

    assign cand_line = next_arr[cand_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                conf_q[i]   <= CF_IDLE;
                last_q[i]   <= '0;
                stride_q[i] <= '0;
                ptr_q[i]    <= '0;
                ahead_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if (touch_valid && (touch_idx == IDX_W'(i))) begin
                    unique case (touch_kind)
                        UPD_MATCH: begin
                            last_q[i] <= acc_line;
                            if (conf_q[i] == CF_TRAIN) begin
                                conf_q[i]  <= CF_STEADY;
                                ptr_q[i]   <= acc_line;
                                ahead_q[i] <= '0;
                            end else if (ahead_q[i] == '0) begin
                                ptr_q[i] <= acc_line;
                            end else begin
                                ahead_q[i] <= ahead_q[i] - 1'b1;
                            end
                        end
                        UPD_RETRAIN: begin
                            stride_q[i] <= acc_line - last_q[i];
                            last_q[i]   <= acc_line;
                            ptr_q[i]    <= acc_line;
                            ahead_q[i]  <= '0;
                            conf_q[i]   <= CF_TRAIN;
                        end
                        UPD_ALLOC: begin
                            stride_q[i] <= '0;
                            last_q[i]   <= acc_line;
                            ptr_q[i]    <= acc_line;
                            ahead_q[i]  <= '0;
                            conf_q[i]   <= CF_SEEN;
                        end
                        default: begin
                        end
                    endcase
                end else if (take && (cand_idx == IDX_W'(i))) begin
                    ptr_q[i]   <= next_arr[i];
                    ahead_q[i] <= ahead_q[i] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pf_issue_fsm.sv
`timescale 1ns/1ps
module pf_issue_fsm
    import pf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pf_mode_e          mode,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_line,
    input  logic              acc_miss,
    input  logic              str_valid,
    input  logic [ADDR_W-1:0] str_line,
    output logic              str_take,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_line
);
    out_state_e        state_q;
    out_state_e        state_d;
    logic              pend_v_q;
    logic [ADDR_W-1:0] pend_q;
    logic              next_mode;
    logic              obl_req;
    logic              load_en;
    logic              have;
    logic              sel_pend;
    logic              sel_str;
    logic              load;
    logic [ADDR_W-1:0] cand;

    assign next_mode = (mode == MODE_NEXT_ALL) || (mode == MODE_NEXT_MISS);
    assign obl_req   = acc_valid && ((mode == MODE_NEXT_ALL)
                                     || ((mode == MODE_NEXT_MISS) && acc_miss));
    assign load_en   = (state_q == OUT_IDLE) || pf_ready;

    // Source priority: fresh next-line request, held next-line request, stream.
    always_comb begin
        have     = 1'b0;
        sel_pend = 1'b0;
        sel_str  = 1'b0;
        cand     = str_line;
        if (obl_req) begin
            have = 1'b1;
            cand = acc_line + 1'b1;
        end else if (pend_v_q && next_mode) begin
            have     = 1'b1;
            sel_pend = 1'b1;
            cand     = pend_q;
        end else if (str_valid) begin
            have    = 1'b1;
            sel_str = 1'b1;
        end
    end

    assign load     = load_en && have;
    assign str_take = load && sel_str;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: state_d = load ? OUT_BUSY : OUT_IDLE;
            OUT_BUSY: begin
                if (pf_ready) begin
                    state_d = load ? OUT_BUSY : OUT_IDLE;
                end
            end
            default: state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_line <= '0;
        end else if (load) begin
            pf_line <= cand;
        end
    end

    assign pf_valid = (state_q == OUT_BUSY);

    // One held next-line request; a newer one replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q <= 1'b0;
            pend_q   <= '0;
        end else if (!next_mode) begin
            pend_v_q <= 1'b0;
        end else if (obl_req && !load) begin
            pend_v_q <= 1'b1;
            pend_q   <= acc_line + 1'b1;
        end else if (obl_req || (load && sel_pend)) begin
            pend_v_q <= 1'b0;
        end
    end

endmodule

// File: rtl/stride_prefetcher.sv
`timescale 1ns/1ps
module stride_prefetcher
    import pf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM       = 8,
    parameter int DIST      = 12,
    parameter int WINDOW    = 16,
    parameter int PAGE_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_line,
    input  logic              acc_miss,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_line
);
    pf_mode_e          mode_e;
    logic              tbl_acc;
    logic              tbl_issue;
    logic              str_valid;
    logic [ADDR_W-1:0] str_line;
    logic              str_take;

    assign mode_e    = pf_mode_e'(mode);
    assign tbl_issue = (mode_e == MODE_STRIDE);
    assign tbl_acc   = acc_valid && tbl_issue;

    pf_stream_table #(
        .ADDR_W    (ADDR_W),
        .NUM       (NUM),
        .DIST      (DIST),
        .WINDOW    (WINDOW),
        .PAGE_LOG2 (PAGE_LOG2)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (tbl_acc),
        .acc_line   (acc_line),
        .issue_en   (tbl_issue),
        .take       (str_take),
        .cand_valid (str_valid),
        .cand_line  (str_line)
    );

    pf_issue_fsm #(.ADDR_W(ADDR_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .acc_valid (acc_valid),
        .acc_line  (acc_line),
        .acc_miss  (acc_miss),
        .str_valid (str_valid),
        .str_line  (str_line),
        .str_take  (str_take),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_line   (pf_line)
    );

endmodule

// File: rtl/pf_checker.sv
`timescale 1ns/1ps
module pf_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_line,
    input logic              acc_miss,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_line
);
    p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

    p_next_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b01) && acc_valid && (!pf_valid || pf_ready))
        |=> (pf_valid && (pf_line == $past(acc_line) + 1'b1)));

    p_next_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b10) && acc_valid && acc_miss && (!pf_valid || pf_ready))
        |=> (pf_valid && (pf_line == $past(acc_line) + 1'b1)));

    p_silent_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b11) && !pf_valid) |=> !pf_valid);

endmodule

bind stride_prefetcher pf_checker #(.ADDR_W(ADDR_W)) u_pf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .acc_valid (acc_valid),
    .acc_line  (acc_line),
    .acc_miss  (acc_miss),
    .pf_valid  (pf_valid),
    .pf_ready  (pf_ready),
    .pf_line   (pf_line)
);

// File: tb/stride_prefetcher_bench.sv
`timescale 1ns/1ps
module stride_prefetcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_line = '0;
    logic        acc_miss = 1'b0;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [31:0] pf_line;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    logic [31:0] exp_q [$];

    always #5 clk = ~clk;

    stride_prefetcher u_stride_prefetcher (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .acc_valid (acc_valid),
        .acc_line  (acc_line),
        .acc_miss  (acc_miss),
        .pf_valid  (pf_valid),
        .pf_ready  (pf_ready),
        .pf_line   (pf_line)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every accepted request.
    always begin
        @(negedge clk);
        #2;
        if (rst_n && pf_valid && pf_ready) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL %s: actual %h expected none", cur_req, pf_line);
            end else begin
                chk(cur_req, pf_line, exp_q.pop_front());
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic access(input logic [31:0] line, input logic miss);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_line  = line;
        acc_miss  = miss;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic push_run(input logic [31:0] first, input logic [31:0] step, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(first + step * i);
        end
    endtask

    task automatic drain(input string req);
        idle(40);
        chk(req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        #1;
        cur_req = "R1";
        chk("R1", pf_valid, 0);

        // R2 / R3: confirm, same-cycle demand on first issue, run-ahead limit
        cur_req = "R3";
        push_run(32'h1004, 1, 12);
        access(32'h1000, 0);
        access(32'h1001, 0);
        access(32'h1002, 0);
        access(32'h1003, 0);
        idle(30);
        chk("R3", exp_q.size(), 0);
        exp_q.push_back(32'h1010);
        access(32'h1004, 0);
        drain("R2");

        // R4: zero stride
        cur_req = "R4";
        access(32'h2000, 0);
        access(32'h2000, 0);
        access(32'h2000, 0);
        access(32'h2000, 0);
        drain("R4");
        chk("R4", pf_valid, 0);

        // R5: negative stride
        cur_req = "R5";
        push_run(32'h302A, 32'hFFFF_FFFE, 12);
        access(32'h3030, 0);
        access(32'h302E, 0);
        access(32'h302C, 0);
        drain("R5");

        // R8: page stop
        cur_req = "R8";
        push_run(32'h403B, 1, 5);
        access(32'h4038, 0);
        access(32'h4039, 0);
        access(32'h403A, 0);
        drain("R8");

        // R7: retrain to a new stride
        cur_req = "R7";
        push_run(32'h5006, 2, 12);
        access(32'h5000, 0);
        access(32'h5002, 0);
        access(32'h5004, 0);
        drain("R7");
        push_run(32'h5013, 5, 9);
        access(32'h5009, 0);
        access(32'h500E, 0);
        drain("R7");

        // R6: eight streams and least-recent replacement
        do_reset();
        cur_req = "R6";
        access(32'h6000, 0);
        access(32'h6001, 0);
        for (int k = 0; k < 7; k++) access(32'h7000 + 32'h100 * k, 0);
        push_run(32'h6003, 1, 12);
        access(32'h6002, 0);
        drain("R6");
        access(32'h8000, 0);
        access(32'h8001, 0);
        for (int k = 0; k < 8; k++) access(32'h9000 + 32'h100 * k, 0);
        access(32'h8002, 0);
        drain("R6");

        // R12: back-pressure
        cur_req = "R12";
        pf_ready = 1'b0;
        access(32'hA000, 0);
        access(32'hA001, 0);
        access(32'hA002, 0);
        idle(5);
        #1;
        chk("R12", pf_valid, 1);
        chk("R12", pf_line, 32'hA003);
        idle(3);
        #1;
        chk("R12", pf_valid, 1);
        chk("R12", pf_line, 32'hA003);
        push_run(32'hA003, 1, 12);
        pf_ready = 1'b1;
        drain("R12");

        // R9: next line on every access
        cur_req = "R9";
        mode = 2'b01;
        exp_q.push_back(32'hB001);
        exp_q.push_back(32'hB011);
        access(32'hB000, 0);
        access(32'hB010, 1);
        drain("R9");

        // R10: next line on miss only
        cur_req = "R10";
        mode = 2'b10;
        exp_q.push_back(32'hC006);
        access(32'hC000, 0);
        access(32'hC005, 1);
        access(32'hC009, 0);
        drain("R10");

        // R11 / R13: off mode, table untouched
        cur_req = "R11";
        mode = 2'b11;
        access(32'hD000, 1);
        access(32'hD001, 1);
        access(32'hD002, 1);
        access(32'hD003, 1);
        drain("R11");
        chk("R11", pf_valid, 0);
        cur_req = "R13";
        mode = 2'b00;
        access(32'hD004, 0);
        drain("R13");
        chk("R13", pf_valid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule